// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block turns exception requests from the rest of a processor core into a completed exception entry. Seven request lines arrive as single-cycle pulses. In each cycle the block drops the interrupt requests that the current status word masks, and then picks one of the remaining requests by a fixed priority. It registers everything the register file and the fetch unit need to enter the handler. That is the handler address, the new processor mode and status word, and write strobes with data for the saved-status slot and the link register of the mode being entered.

A single bit of the system control word moves the whole vector table. When the bit is clear the table sits at the bottom of the address space. When it is set the table sits at the high base. Each exception kind has a fixed slot in the table and a fixed mode. Storage of the banked registers, pipeline flushing and return from an exception belong to other blocks.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A request present on `req_i` at a rising clock edge produces `taken_o` high for exactly the next clock cycle. With no eligible request, `taken_o` is low and the other registered outputs hold their previous values. The request bit positions on `req_i` are: bit0 reset, bit1 undefined instruction, bit2 software interrupt, bit3 prefetch abort, bit4 data abort, bit5 interrupt, bit6 fast interrupt.
- R2: The handler address base is 0x00000000 when bit 13 of `ctrl_i` is clear and 0xFFFF0000 when that bit is set.
- R3: The offset added to the base is 0x00 for reset, 0x04 for undefined instruction, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for interrupt and 0x1C for fast interrupt. Offset 0x14 is never produced.
- R4: The entered mode is 5'h13 (supervisor) for reset and software interrupt, 5'h1B (undefined) for undefined instruction, 5'h17 (abort) for both aborts, 5'h12 for interrupt and 5'h11 for fast interrupt.
- R5: When several eligible requests arrive together, the order of service from first to last is reset, data abort, fast interrupt, interrupt, prefetch abort, undefined instruction, software interrupt. Only one of them is served.
- R6: An interrupt request is ignored while bit 7 of `cur_status_i` is set. A fast-interrupt request is ignored while bit 6 is set. An ignored request does not block a lower-priority request in the same cycle.
- R7: The new status word `status_o` equals the prior status word with bits [4:0] replaced by the new mode and bit 7 set. Bit 6 is also set on reset and fast-interrupt entry and is unchanged otherwise.
- R8: On entry, `spsr_we_o` pulses with `taken_o`, and `spsr_wdata_o` carries the status word that `cur_status_i` held when the request was sampled.
- R9: On entry, `lr_we_o` pulses with `taken_o`, and `lr_wdata_o` carries the value that `ret_addr_i` held when the request was sampled.
- R10: While `rst_n` is low, `taken_o`, both strobes and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 7 | Single-cycle exception requests, one bit per kind |
| ctrl_i | input | 32 | System control word; bit 13 selects the high vector table |
| cur_status_i | input | 32 | Current program status word |
| ret_addr_i | input | 32 | Return address to place in the link register |
| taken_o | output | 1 | One-cycle pulse marking a completed entry |
| pc_o | output | 32 | Handler address (new program counter) |
| mode_o | output | 5 | Mode entered |
| status_o | output | 32 | New program status word |
| spsr_we_o | output | 1 | Write strobe for the saved-status slot of `mode_o` |
| spsr_wdata_o | output | 32 | Saved status value |
| lr_we_o | output | 1 | Write strobe for the link register of `mode_o` |
| lr_wdata_o | output | 32 | Link register value |

## Verification
The properties compare each entry with the inputs sampled one edge earlier. They therefore assume that `ctrl_i`, `cur_status_i` and `ret_addr_i` are stable through the sampling edge, and that every request is a single-cycle pulse and not a level. The bench changes all inputs only on falling edges and holds each value for one full cycle. Each request vector it drives lives for exactly one cycle. The random phase keeps requests sparse, so that idle cycles with held outputs are seen as often as entries.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int WORD_W   = 32;
    localparam int MODE_W   = 5;
    localparam int NUM_EXC  = 7;
    localparam int KIND_W   = 3;
    localparam int OFFS_SHIFT = 2;

    // request line positions
    localparam int RQ_RESET = 0;
    localparam int RQ_UNDEF = 1;
    localparam int RQ_SWI   = 2;
    localparam int RQ_PABT  = 3;
    localparam int RQ_DABT  = 4;
    localparam int RQ_IRQ   = 5;
    localparam int RQ_FIQ   = 6;

    // status word fields
    localparam int ST_IRQ_DIS = 7;
    localparam int ST_FIQ_DIS = 6;

    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;

    // kind value times four is the table offset; value 5 is the reserved slot
    typedef enum logic [KIND_W-1:0] {
        EK_RESET = 3'd0,
        EK_UNDEF = 3'd1,
        EK_SWI   = 3'd2,
        EK_PABT  = 3'd3,
        EK_DABT  = 3'd4,
        EK_IRQ   = 3'd6,
        EK_FIQ   = 3'd7
    } exc_kind_e;

    // service order, first entry wins
    localparam int SERVE_ORDER [NUM_EXC] = '{RQ_RESET, RQ_DABT, RQ_FIQ, RQ_IRQ,
                                            RQ_PABT, RQ_UNDEF, RQ_SWI};

    typedef struct packed {
        logic                taken;
        logic [WORD_W-1:0]   pc;
        logic [MODE_W-1:0]   mode;
        logic [WORD_W-1:0]   status;
        logic [WORD_W-1:0]   saved;
        logic [WORD_W-1:0]   link;
    } entry_s;

    function automatic exc_kind_e line_to_kind(input int line);
        case (line)
            RQ_RESET: return EK_RESET;
            RQ_UNDEF: return EK_UNDEF;
            RQ_SWI:   return EK_SWI;
            RQ_PABT:  return EK_PABT;
            RQ_DABT:  return EK_DABT;
            RQ_IRQ:   return EK_IRQ;
            default:  return EK_FIQ;
        endcase
    endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
(
    input  logic [NUM_EXC-1:0] req_i,
    input  logic               irq_dis_i,
    input  logic               fiq_dis_i,
    output logic               valid_o,
    output exc_kind_e          kind_o
);
    logic [NUM_EXC-1:0] elig;

    always_comb begin
        elig         = req_i;
        elig[RQ_IRQ] = req_i[RQ_IRQ] & ~irq_dis_i;
        elig[RQ_FIQ] = req_i[RQ_FIQ] & ~fiq_dis_i;
    end

    // walk from lowest to highest priority so the highest overwrites
    always_comb begin
        valid_o = 1'b0;
        kind_o  = EK_RESET;
        for (int i = NUM_EXC - 1; i >= 0; i--) begin
            if (elig[SERVE_ORDER[i]]) begin
                valid_o = 1'b1;
                kind_o  = line_to_kind(SERVE_ORDER[i]);
            end
        end
    end
endmodule

// File: rtl/exc_vector_map.sv
module exc_vector_map
    import exc_entry_pkg::*;
#(
    parameter logic [WORD_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  exc_kind_e          kind_i,
    input  logic               high_i,
    output logic [WORD_W-1:0]  addr_o,
    output logic [MODE_W-1:0]  mode_o,
    output logic               mask_fiq_o
);
    localparam int OFFS_W = KIND_W + OFFS_SHIFT;

    logic [WORD_W-1:0] base;
    logic [OFFS_W-1:0] offs;

    always_comb begin
        base   = high_i ? HIGH_BASE : '0;
        offs   = {kind_i, {OFFS_SHIFT{1'b0}}};
        addr_o = base | {{(WORD_W-OFFS_W){1'b0}}, offs};
    end

    always_comb begin
        mask_fiq_o = 1'b0;
        case (kind_i)
            EK_RESET: begin mode_o = MODE_SVC; mask_fiq_o = 1'b1; end
            EK_SWI:   mode_o = MODE_SVC;
            EK_UNDEF: mode_o = MODE_UND;
            EK_PABT,
            EK_DABT:  mode_o = MODE_ABT;
            EK_IRQ:   mode_o = MODE_IRQ;
            EK_FIQ:   begin mode_o = MODE_FIQ; mask_fiq_o = 1'b1; end
            default:  mode_o = MODE_SVC;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int                HIVEC_BIT = 13,
    parameter logic [WORD_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EXC-1:0]  req_i,
    input  logic [WORD_W-1:0]   ctrl_i,
    input  logic [WORD_W-1:0]   cur_status_i,
    input  logic [WORD_W-1:0]   ret_addr_i,
    output logic                taken_o,
    output logic [WORD_W-1:0]   pc_o,
    output logic [MODE_W-1:0]   mode_o,
    output logic [WORD_W-1:0]   status_o,
    output logic                spsr_we_o,
    output logic [WORD_W-1:0]   spsr_wdata_o,
    output logic                lr_we_o,
    output logic [WORD_W-1:0]   lr_wdata_o
);
    logic               pick_valid;
    exc_kind_e          pick_kind;
    logic [WORD_W-1:0]  vec_addr;
    logic [MODE_W-1:0]  vec_mode;
    logic               vec_mask_fiq;

    entry_s state_d, state_q;

    exc_arbiter i_arb (
        .req_i     (req_i),
        .irq_dis_i (cur_status_i[ST_IRQ_DIS]),
        .fiq_dis_i (cur_status_i[ST_FIQ_DIS]),
        .valid_o   (pick_valid),
        .kind_o    (pick_kind)
    );

    exc_vector_map #(.HIGH_BASE(HIGH_BASE)) i_map (
        .kind_i     (pick_kind),
        .high_i     (ctrl_i[HIVEC_BIT]),
        .addr_o     (vec_addr),
        .mode_o     (vec_mode),
        .mask_fiq_o (vec_mask_fiq)
    );

    always_comb begin
        state_d       = state_q;
        state_d.taken = 1'b0;
        if (pick_valid) begin
            state_d.taken  = 1'b1;
            state_d.pc     = vec_addr;
            state_d.mode   = vec_mode;
            state_d.status = cur_status_i;
            state_d.status[MODE_W-1:0]  = vec_mode;
            state_d.status[ST_IRQ_DIS]  = 1'b1;
            if (vec_mask_fiq) begin
                state_d.status[ST_FIQ_DIS] = 1'b1;
            end
            state_d.saved  = cur_status_i;
            state_d.link   = ret_addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign taken_o      = state_q.taken;
    assign pc_o         = state_q.pc;
    assign mode_o       = state_q.mode;
    assign status_o     = state_q.status;
    assign spsr_we_o    = state_q.taken;
    assign spsr_wdata_o = state_q.saved;
    assign lr_we_o      = state_q.taken;
    assign lr_wdata_o   = state_q.link;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int HIVEC_BIT = 13
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_EXC-1:0]  req_i,
    input logic [WORD_W-1:0]   ctrl_i,
    input logic [WORD_W-1:0]   cur_status_i,
    input logic [WORD_W-1:0]   ret_addr_i,
    input logic                taken_o,
    input logic [WORD_W-1:0]   pc_o,
    input logic [MODE_W-1:0]   mode_o,
    input logic [WORD_W-1:0]   status_o,
    input logic                spsr_we_o,
    input logic [WORD_W-1:0]   spsr_wdata_o,
    input logic                lr_we_o,
    input logic [WORD_W-1:0]   lr_wdata_o
);
    a_r1_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> $past(|req_i));

    a_r2_table_base: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (pc_o[31:16] == ($past(ctrl_i[HIVEC_BIT]) ? 16'hFFFF : 16'h0000)));

    a_r3_slot_legal: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (pc_o[4:0] != 5'h14 && pc_o[1:0] == 2'b00 && pc_o[15:5] == '0));

    a_r5_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && $past(req_i[RQ_RESET])) |-> (mode_o == MODE_SVC && pc_o[4:0] == 5'h00));

    a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && mode_o == MODE_IRQ) |-> !$past(cur_status_i[ST_IRQ_DIS]));

    a_r6_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && mode_o == MODE_FIQ) |-> !$past(cur_status_i[ST_FIQ_DIS]));

    a_r7_new_status: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (status_o[ST_IRQ_DIS] && status_o[MODE_W-1:0] == mode_o));

    a_r8_saved_status: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (spsr_we_o && spsr_wdata_o == $past(cur_status_i)));

    a_r9_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (lr_we_o && lr_wdata_o == $past(ret_addr_i)));

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken_o && !spsr_we_o) |-> (!lr_we_o));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.HIVEC_BIT(HIVEC_BIT)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .ctrl_i       (ctrl_i),
    .cur_status_i (cur_status_i),
    .ret_addr_i   (ret_addr_i),
    .taken_o      (taken_o),
    .pc_o         (pc_o),
    .mode_o       (mode_o),
    .status_o     (status_o),
    .spsr_we_o    (spsr_we_o),
    .spsr_wdata_o (spsr_wdata_o),
    .lr_we_o      (lr_we_o),
    .lr_wdata_o   (lr_wdata_o)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  req = '0;
    logic [31:0] ctrl = '0;
    logic [31:0] st = '0;
    logic [31:0] ret = '0;

    logic        taken_o, spsr_we_o, lr_we_o;
    logic [31:0] pc_o, status_o, spsr_wdata_o, lr_wdata_o;
    logic [4:0]  mode_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // reference state
    logic        e_taken = 1'b0;
    logic [31:0] e_pc = '0, e_status = '0, e_saved = '0, e_link = '0;
    logic [4:0]  e_mode = '0;

    always #10 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ctrl_i(ctrl),
        .cur_status_i(st), .ret_addr_i(ret),
        .taken_o(taken_o), .pc_o(pc_o), .mode_o(mode_o), .status_o(status_o),
        .spsr_we_o(spsr_we_o), .spsr_wdata_o(spsr_wdata_o),
        .lr_we_o(lr_we_o), .lr_wdata_o(lr_wdata_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string ctx);
        chk({"R1 taken ", ctx}, {31'd0, taken_o}, {31'd0, e_taken});
        chk({"R8 spsr_we ", ctx}, {31'd0, spsr_we_o}, {31'd0, e_taken});
        chk({"R9 lr_we ", ctx}, {31'd0, lr_we_o}, {31'd0, e_taken});
        chk({"R2/R3 pc ", ctx}, pc_o, e_pc);
        chk({"R4 mode ", ctx}, {27'd0, mode_o}, {27'd0, e_mode});
        chk({"R7 status ", ctx}, status_o, e_status);
        chk({"R8 saved ", ctx}, spsr_wdata_o, e_saved);
        chk({"R9 link ", ctx}, lr_wdata_o, e_link);
    endtask

    // behavioural model of one sampling edge
    task automatic model();
        int order [7] = '{0, 4, 6, 5, 3, 1, 2};
        int offs  [7] = '{0, 4, 8, 12, 16, 24, 28};
        logic [4:0] modes [7] = '{5'h13, 5'h1B, 5'h13, 5'h17, 5'h17, 5'h12, 5'h11};
        int pick = -1;
        for (int i = 0; i < 7; i++) begin
            int b = order[i];
            if (pick < 0 && req[b] && !(b == 5 && st[7]) && !(b == 6 && st[6]))
                pick = b;
        end
        e_taken = (pick >= 0);
        if (pick >= 0) begin
            e_pc = (ctrl[13] ? 32'hFFFF0000 : 32'h0) + offs[pick];
            e_mode = modes[pick];
            e_status = st;
            e_status[4:0] = modes[pick];
            e_status[7] = 1'b1;
            if (pick == 0 || pick == 6) e_status[6] = 1'b1;
            e_saved = st;
            e_link = ret;
        end
    endtask

    // inputs applied just after a falling edge; results checked at the next one
    task automatic step(input logic [6:0] r, input logic [31:0] c,
                        input logic [31:0] s, input logic [31:0] a, input string ctx);
        req = r; ctrl = c; st = s; ret = a;
        model();
        @(negedge clk);
        compare_all(ctx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R10: everything zero under reset, even with requests present
        req = 7'h7F; ctrl = 32'h2000; st = 32'h0; ret = 32'h1234;
        repeat (3) @(negedge clk);
        compare_all("R10 in reset");
        req = '0;
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R10 after release");

        // R2 base select, R3 offsets, R4 modes: each kind alone, both tables
        for (int hv = 0; hv < 2; hv++) begin
            for (int k = 0; k < 7; k++) begin
                step(7'(1 << k), hv ? 32'h0000_2000 : 32'hFFFF_DFFF, 32'h0000_0010,
                     32'h100 + 32'(k), "R3 single kind");
                step(7'h00, 32'h0, 32'h0, 32'hDEAD, "R1 idle hold");
            end
        end

        // R5 priority: all at once, then peel off the winner each time
        step(7'h7F, 32'h0, 32'h0, 32'h1, "R5 all");
        step(7'h7E, 32'h0, 32'h0, 32'h2, "R5 no reset");
        step(7'h6E, 32'h0, 32'h0, 32'h3, "R5 fiq wins");
        step(7'h2E, 32'h0, 32'h0, 32'h4, "R5 irq wins");
        step(7'h0E, 32'h0, 32'h0, 32'h5, "R5 pabt wins");
        step(7'h06, 32'h0, 32'h0, 32'h6, "R5 undef over swi");

        // R6 masking
        step(7'h20, 32'h0, 32'h80, 32'h7, "R6 irq masked alone");
        step(7'h40, 32'h0, 32'h40, 32'h8, "R6 fiq masked alone");
        step(7'h60, 32'h0, 32'h40, 32'h9, "R6 fiq masked irq served");
        step(7'h64, 32'h0, 32'hC0, 32'hA, "R6 both masked swi served");
        step(7'h40, 32'h0, 32'h80, 32'hB, "R6 fiq open under irq mask");

        // R7 bit 6 kept on non-fiq entry when already set in the prior word
        step(7'h04, 32'h0, 32'hF000_005F, 32'hC, "R7 keep bit6");
        step(7'h02, 32'h2000, 32'h0000_0000, 32'hD, "R7 bit6 clear");

        // back-to-back entries
        step(7'h01, 32'h2000, 32'h3, 32'hE, "R1 back to back a");
        step(7'h10, 32'h2000, 32'h3, 32'hF, "R1 back to back b");
        step(7'h00, 32'h2000, 32'h3, 32'h0, "R1 after pair");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [6:0] r = 7'($urandom) & 7'($urandom) & 7'($urandom);
            step(r, $urandom, $urandom, $urandom, "random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule